// File: doc/BRIEF.md
# Trace Message Packer

This block takes one debug trace message at a time and streams it onto a narrow trace port. The port has a 12-bit data bus and a 2-bit control bus. The message is a sequence of fields. Each field is either fixed-width or variable-length, and the fields are laid end to end starting from the least significant bit. A variable-length field carries only its significant bits and closes a packet. The control code on each beat tells a receiver whether the beat continues a packet, closes a packet, or closes the whole message.

The block builds two kinds of message:

- **Branch message.** It carries a 6-bit type code, a 4-bit source ID and a variable-length instruction count.
- **Data-write message.** It carries the type code, the source ID, a 3-bit access-size code, a variable-length compressed address and the write data.

The producer hands over a message with a valid/ready handshake. The producer may offer the next message during the final beat of the current one, so consecutive messages run back to back.

Top module: `trc_packer`

## Requirements
- R1: During and after reset, and whenever no message is being sent, the control bus reads 2'b11, the data bus reads zero and `msg_ready` is high.
- R2: The first beat of every message carries control 2'b00, the type code in bits [5:0] (3 for a branch message, 5 for a data-write message) and the source ID in bits [9:6].
- R3: Fixed fields follow one another without gaps, least significant bit first, and may straddle beats. For a data-write message, size-code bits 1:0 sit in bits [11:10] of the first beat and size-code bit 2 sits in bit 0 of the second beat.
- R4: A variable field (instruction count or address) begins at the bit right after the preceding field. Its length is the index of its highest set bit plus one, with a minimum of 1. Bits above the packet's last bit in its closing beat are zero. The next packet begins at bit 0 of a fresh beat, and a packet ending exactly on a beat boundary adds no extra beat.
- R5: Control codes mean: 2'b00 for a beat that does not close its packet, 2'b01 for the closing beat of a packet that is not the last, and 2'b11 for the final beat of the message. Code 2'b10 is never driven, and a 2'b11 beat is followed only by 2'b11 or 2'b00.
- R6: Write data forms the last packet of a data-write message. Its length comes from the size code: 0 gives 8 bits, 1 gives 16 bits, and any other value gives 32 bits. Data bits above that length are sent as zero.
- R7: The first packet of a branch message always spans at least two beats. If its bits fit in 12, it is extended with zeros to 13 bits, giving a zero second beat that closes the message.
- R8: A message is taken on a rising edge with `msg_valid` and `msg_ready` both high. Its first beat appears after the second rising edge that follows. `msg_ready` stays low from the edge after acceptance until the message's final beat is the one about to be driven.
- R9: A message accepted while the previous message's final beat is about to be driven starts on the very next beat, with no idle beat between them.
- R10: Message fields are sampled only at acceptance. Field values or `msg_valid` at any other time have no effect on the beats sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A message is offered |
| msg_ready | output | 1 | The packer can take a message at this edge |
| msg_kind | input | 1 | 0 = branch message, 1 = data-write message |
| msg_src | input | 4 | Source ID |
| msg_dsz | input | 3 | Access-size code (data-write only) |
| msg_icnt | input | ICNT_W (16) | Instruction count (branch only) |
| msg_addr | input | ADDR_W (32) | Compressed address (data-write only) |
| msg_data | input | DATA_W (32) | Write data (data-write only) |
| tp_data | output | 12 | Trace port data beat |
| tp_ctl | output | 2 | Trace port control code |

## Verification
Two events can fall in the same cycle: the final beat of one message (code 2'b11) is driven, and the next message is accepted through the handshake. The bench provokes this by holding `msg_valid` high across whole messages, so every message after the first is accepted exactly on its predecessor's last beat. It also mixes in random idle gaps. A behavioural model turns each accepted message into a queue of expected beats, and every cycle's control code, data and `msg_ready` are compared with it. Any lost, duplicated or idle beat between the two messages therefore shows up as a mismatch. Edge lengths are covered separately: an instruction count that fits the first beat, an address that ends a packet exactly on a beat boundary, and each data size.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int OUT_W   = 12;
  localparam int CTL_W   = 2;
  localparam int TCODE_W = 6;
  localparam int SRC_W   = 4;
  localparam int DSZ_W   = 3;
  localparam int HDR_W   = TCODE_W + SRC_W;   // type + source
  localparam int WRF_W   = HDR_W + DSZ_W;     // fixed part of a write
  localparam int MIN_P0  = OUT_W + 1;         // first packet spans two beats

  typedef enum logic [CTL_W-1:0] {
    CTL_CONT    = 2'b00,
    CTL_PKT_END = 2'b01,
    CTL_MSG_END = 2'b11
  } ctl_e;

  typedef enum logic {
    KIND_BRANCH = 1'b0,
    KIND_WRITE  = 1'b1
  } kind_e;

  localparam logic [TCODE_W-1:0] TC_BRANCH = 6'd3;
  localparam logic [TCODE_W-1:0] TC_WRITE  = 6'd5;
endpackage

// File: rtl/trc_sig_len.sv
// Significant length of a value: index of highest set bit plus one, min 1.
module trc_sig_len #(
  parameter int W  = 16,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [LW-1:0] len
);
  always_comb begin
    len = LW'(1);
    for (int i = 0; i < W; i++) begin
      if (value[i]) len = LW'(i + 1);
    end
  end
endmodule

// File: rtl/trc_assemble.sv
// Lays the fields of one message into up to two packets.
module trc_assemble
  import trc_pkg::*;
#(
  parameter int ICNT_W = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PKT_W  = 45,
  parameter int LEN_W  = 6,
  parameter int IL_W   = 5,
  parameter int AL_W   = 6,
  parameter int DLEN_W = 6
) (
  input  logic              kind,
  input  logic [SRC_W-1:0]  src,
  input  logic [DSZ_W-1:0]  dsz,
  input  logic [ICNT_W-1:0] icnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [IL_W-1:0]   icnt_len,
  input  logic [AL_W-1:0]   addr_len,
  output logic [PKT_W-1:0]  pkt0,
  output logic [LEN_W-1:0]  len0,
  output logic [DATA_W-1:0] pkt1,
  output logic [DLEN_W-1:0] len1,
  output logic              has_p1
);
  logic [LEN_W-1:0] br_len;

  always_comb begin
    br_len = LEN_W'(HDR_W) + LEN_W'(icnt_len);
    if (kind_e'(kind) == KIND_WRITE) begin
      pkt0   = (PKT_W'(addr) << WRF_W) | (PKT_W'(dsz) << HDR_W)
             | (PKT_W'(src) << TCODE_W) | PKT_W'(TC_WRITE);
      len0   = LEN_W'(WRF_W) + LEN_W'(addr_len);
      has_p1 = 1'b1;
    end else begin
      pkt0   = (PKT_W'(icnt) << HDR_W) | (PKT_W'(src) << TCODE_W)
             | PKT_W'(TC_BRANCH);
      len0   = (br_len < LEN_W'(MIN_P0)) ? LEN_W'(MIN_P0) : br_len;
      has_p1 = 1'b0;
    end
  end

  always_comb begin
    case (dsz)
      3'd0:    len1 = DLEN_W'(8);
      3'd1:    len1 = DLEN_W'(16);
      default: len1 = DLEN_W'(DATA_W);
    endcase
    for (int i = 0; i < DATA_W; i++) begin
      pkt1[i] = data[i] && (i < int'(len1));
    end
  end
endmodule

// File: rtl/trc_serializer.sv
// Cuts packets into 12-bit beats with registered data and control outputs.
module trc_serializer
  import trc_pkg::*;
#(
  parameter int PKT_W  = 45,
  parameter int LEN_W  = 6,
  parameter int DATA_W = 32,
  parameter int DLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PKT_W-1:0]  pkt0,
  input  logic [LEN_W-1:0]  len0,
  input  logic [DATA_W-1:0] pkt1,
  input  logic [DLEN_W-1:0] len1,
  input  logic              has_p1,
  output logic              ready,
  output logic [OUT_W-1:0]  beat_data,
  output logic [CTL_W-1:0]  beat_ctl
);
  logic              busy;
  logic [PKT_W-1:0]  sh;
  logic [LEN_W-1:0]  rem;
  logic [DATA_W-1:0] p1;
  logic [DLEN_W-1:0] p1_len;
  logic              p1_pend;
  logic              fits;
  ctl_e              ctl_now;

  assign fits  = (rem <= LEN_W'(OUT_W));
  assign ready = !busy || (fits && !p1_pend);

  always_comb begin
    if (!fits)       ctl_now = CTL_CONT;
    else if (p1_pend) ctl_now = CTL_PKT_END;
    else             ctl_now = CTL_MSG_END;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sh        <= '0;
      rem       <= '0;
      p1        <= '0;
      p1_len    <= '0;
      p1_pend   <= 1'b0;
      beat_data <= '0;
      beat_ctl  <= CTL_MSG_END;
    end else begin
      if (busy) begin
        beat_data <= sh[OUT_W-1:0];
        beat_ctl  <= ctl_now;
        if (!fits) begin
          sh  <= sh >> OUT_W;
          rem <= rem - LEN_W'(OUT_W);
        end else if (p1_pend) begin
          sh      <= PKT_W'(p1);
          rem     <= LEN_W'(p1_len);
          p1_pend <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        beat_data <= '0;
        beat_ctl  <= CTL_MSG_END;
      end
      if (load) begin
        busy    <= 1'b1;
        sh      <= pkt0;
        rem     <= len0;
        p1      <= pkt1;
        p1_len  <= len1;
        p1_pend <= has_p1;
      end
    end
  end
endmodule

// File: rtl/trc_packer.sv
module trc_packer
  import trc_pkg::*;
#(
  parameter int ICNT_W = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic              msg_kind,
  input  logic [3:0]        msg_src,
  input  logic [2:0]        msg_dsz,
  input  logic [ICNT_W-1:0] msg_icnt,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  output logic [11:0]       tp_data,
  output logic [1:0]        tp_ctl
);
  localparam int BR_W   = HDR_W + ICNT_W;
  localparam int WR_W   = WRF_W + ADDR_W;
  localparam int P0_W   = (BR_W > WR_W) ? BR_W : WR_W;
  localparam int PKT_W  = (P0_W > DATA_W) ? P0_W : DATA_W;
  localparam int LEN_W  = $clog2(PKT_W + 1);
  localparam int IL_W   = $clog2(ICNT_W + 1);
  localparam int AL_W   = $clog2(ADDR_W + 1);
  localparam int DLEN_W = $clog2(DATA_W + 1);

  logic [IL_W-1:0]   icnt_len;
  logic [AL_W-1:0]   addr_len;
  logic [PKT_W-1:0]  pkt0;
  logic [LEN_W-1:0]  len0;
  logic [DATA_W-1:0] pkt1;
  logic [DLEN_W-1:0] len1;
  logic              has_p1;
  logic              load;

  trc_sig_len #(.W(ICNT_W), .LW(IL_W)) u_icnt_len (
    .value(msg_icnt), .len(icnt_len));

  trc_sig_len #(.W(ADDR_W), .LW(AL_W)) u_addr_len (
    .value(msg_addr), .len(addr_len));

  trc_assemble #(
    .ICNT_W(ICNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PKT_W(PKT_W),
    .LEN_W(LEN_W), .IL_W(IL_W), .AL_W(AL_W), .DLEN_W(DLEN_W)
  ) u_asm (
    .kind(msg_kind), .src(msg_src), .dsz(msg_dsz), .icnt(msg_icnt),
    .addr(msg_addr), .data(msg_data), .icnt_len(icnt_len),
    .addr_len(addr_len), .pkt0(pkt0), .len0(len0), .pkt1(pkt1),
    .len1(len1), .has_p1(has_p1));

  assign load = msg_valid && msg_ready;

  trc_serializer #(
    .PKT_W(PKT_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .DLEN_W(DLEN_W)
  ) u_ser (
    .clk(clk), .rst(rst), .load(load), .pkt0(pkt0), .len0(len0),
    .pkt1(pkt1), .len1(len1), .has_p1(has_p1), .ready(msg_ready),
    .beat_data(tp_data), .beat_ctl(tp_ctl));
endmodule

// File: rtl/trc_packer_chk.sv
module trc_packer_chk (
  input logic        clk,
  input logic        rst,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [11:0] tp_data,
  input logic [1:0]  tp_ctl
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tp_ctl == 2'b11 && tp_data == 12'd0 && msg_ready));

  // R5
  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
    tp_ctl != 2'b10);

  // R5
  a_r5_start_after_end: assert property (@(posedge clk) disable iff (rst)
    tp_ctl == 2'b11 |=> (tp_ctl == 2'b11 || tp_ctl == 2'b00));

  // R8
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_ready);

  // R8
  a_r8_first_beat_code: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |-> ##2 tp_ctl == 2'b00);

  // R2
  a_r2_type_code: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |-> ##2 (tp_data[5:0] == 6'd3 || tp_data[5:0] == 6'd5));
endmodule

bind trc_packer trc_packer_chk u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .tp_data(tp_data), .tp_ctl(tp_ctl));

// File: tb/trc_packer_tb.sv
`timescale 1ns/1ps
module trc_packer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic        msg_kind = 1'b0;
  logic [3:0]  msg_src = '0;
  logic [2:0]  msg_dsz = '0;
  logic [15:0] msg_icnt = '0;
  logic [31:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic [11:0] tp_data;
  logic [1:0]  tp_ctl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [1:0]  ctl;
    logic [11:0] data;
    string       tag;
  } beat_t;

  beat_t exp_q[$];
  beat_t cur;
  bit    bits[$];

  bit          acc_pend = 0;
  logic        a_kind;
  logic [3:0]  a_src;
  logic [2:0]  a_dsz;
  logic [15:0] a_icnt;
  logic [31:0] a_addr;
  logic [31:0] a_data;
  string       a_tag;

  always #2 clk = ~clk;

  trc_packer u_dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_kind(msg_kind), .msg_src(msg_src), .msg_dsz(msg_dsz),
    .msg_icnt(msg_icnt), .msg_addr(msg_addr), .msg_data(msg_data),
    .tp_data(tp_data), .tp_ctl(tp_ctl));

  function automatic int sig_len(logic [63:0] v);
    int n = 1;
    for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  function automatic void put(logic [63:0] v, int n);
    for (int i = 0; i < n; i++) bits.push_back(v[i]);
  endfunction

  function automatic void close_pkt(logic [1:0] endc, string tag);
    int n = bits.size();
    int nb = (n + 11) / 12;
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      b.data = '0;
      for (int j = 0; j < 12; j++)
        if (k * 12 + j < n) b.data[j] = bits[k * 12 + j];
      b.ctl = (k == nb - 1) ? endc : 2'b00;
      b.tag = tag;
      exp_q.push_back(b);
    end
    bits.delete();
  endfunction

  function automatic void model_msg();
    put(a_kind ? 64'd5 : 64'd3, 6);
    put(64'(a_src), 4);
    if (a_kind) begin
      int dl;
      put(64'(a_dsz), 3);
      put(64'(a_addr), sig_len(64'(a_addr)));
      close_pkt(2'b01, a_tag);
      dl = (a_dsz == 3'd0) ? 8 : (a_dsz == 3'd1) ? 16 : 32;
      put(64'(a_data), dl);
      close_pkt(2'b11, a_tag);
    end else begin
      put(64'(a_icnt), sig_len(64'(a_icnt)));
      while (bits.size() < 13) bits.push_back(1'b0);
      close_pkt(2'b11, a_tag);
    end
  endfunction

  task automatic tick();
    @(posedge clk);
    cycles++;
    if (exp_q.size() > 0) cur = exp_q.pop_front();
    else begin
      cur.ctl = 2'b11; cur.data = '0; cur.tag = "R1";
    end
    if (acc_pend) begin
      model_msg();
      acc_pend = 0;
    end
    @(negedge clk);
    checks++;
    if (tp_ctl !== cur.ctl || tp_data !== cur.data) begin
      errors++;
      $display("FAIL %s beat: actual ctl=%b data=%h expected ctl=%b data=%h",
               cur.tag, tp_ctl, tp_data, cur.ctl, cur.data);
    end
    checks++;
    if (msg_ready !== (exp_q.size() <= 1)) begin
      errors++;
      $display("FAIL R8 ready: actual %b expected %b", msg_ready, exp_q.size() <= 1);
    end
  endtask

  task automatic send(logic kind, logic [3:0] src, logic [2:0] dsz,
                      logic [15:0] icnt, logic [31:0] addr, logic [31:0] data,
                      string tag);
    bit done = 0;
    msg_valid = 1'b1; msg_kind = kind; msg_src = src; msg_dsz = dsz;
    msg_icnt = icnt; msg_addr = addr; msg_data = data;
    while (!done) begin
      #1;
      if (msg_ready) begin
        acc_pend = 1; done = 1;
        a_kind = kind; a_src = src; a_dsz = dsz;
        a_icnt = icnt; a_addr = addr; a_data = data; a_tag = tag;
      end
      tick();
    end
    // R10: fields change right after acceptance; model keeps accepted values
    msg_src = ~src; msg_icnt = ~icnt; msg_addr = ~addr; msg_data = ~data;
    msg_dsz = ~dsz;
  endtask

  task automatic idle(int n);
    msg_valid = 1'b0;
    msg_kind = ~msg_kind; msg_addr = 32'hDEAD_BEEF; // R10: ignored while not valid
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick();   // R1 during reset
    rst = 1'b0;
    idle(2);                              // R1 idle after reset
    // R7: instruction counts fitting the first beat
    send(1'b0, 4'h2, 3'd0, 16'h0000, 32'h0, 32'h0, "R7");
    idle(1);
    send(1'b0, 4'h9, 3'd0, 16'h0003, 32'h0, 32'h0, "R7");
    idle(2);
    // R2 R4: count spilling into second beat, then a full-width count
    send(1'b0, 4'hA, 3'd0, 16'h000D, 32'h0, 32'h0, "R2");
    idle(1);
    send(1'b0, 4'hF, 3'd0, 16'hFFFF, 32'h0, 32'h0, "R4");
    idle(1);
    // R3 R6: each size code
    send(1'b1, 4'h5, 3'd0, 16'h0, 32'h0000_000A, 32'h1234_56A5, "R6");
    idle(1);
    send(1'b1, 4'h6, 3'd1, 16'h0, 32'h0000_0003, 32'hCAFE_8001, "R6");
    idle(1);
    send(1'b1, 4'h7, 3'd2, 16'h0, 32'h0000_0001, 32'h8765_4321, "R3");
    idle(1);
    send(1'b1, 4'h3, 3'd5, 16'h0, 32'h0000_0000, 32'hFFFF_FFFF, "R6");
    idle(1);
    // R4: address ending exactly on a beat boundary, then full address
    send(1'b1, 4'h1, 3'd1, 16'h0, 32'h0000_0400, 32'h0000_BEEF, "R4");
    idle(1);
    send(1'b1, 4'hC, 3'd7, 16'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R4");
    // R9: back-to-back messages
    send(1'b0, 4'h4, 3'd0, 16'h0001, 32'h0, 32'h0, "R9");
    send(1'b1, 4'h8, 3'd0, 16'h0, 32'h0000_0FFF, 32'h0000_0077, "R9");
    send(1'b0, 4'hB, 3'd0, 16'h1234, 32'h0, 32'h0, "R9");
    idle(2);
    // random mix with and without gaps
    for (int m = 0; m < 60; m++) begin
      send(1'($urandom), 4'($urandom), 3'($urandom), 16'($urandom >> ($urandom % 16)),
           32'($urandom >> ($urandom % 32)), 32'($urandom), "R9");
      if ($urandom % 3 == 0) idle($urandom % 3);
    end
    idle(8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule